// File: doc/BRIEF.md
# Two-Bank Interleaved Word Memory

This block presents a single word-addressed synchronous memory built from two half-size banks. The lowest address bit picks which bank serves a request. The remaining address bits form a row index that is wired to both banks. On any cycle, only the chosen bank is enabled. The other bank stays quiet, so each access costs the energy of one half-size array rather than one full-size array.

Each bank registers its read word. A one-bit register records which bank served the last request and steers the output multiplexer on the following cycle. Writes reach only the chosen bank. An access with both read and write requested stores the new word but returns the word that was there before the write. During cycles with no request, both banks stay disabled and the output holds its last value.

The per-bank enables are brought out as an output. Power-analysis or activity checks can observe them there. The arrays are behavioural and the widths are parameters. With the full-size setting of a 15-bit address and 32-bit words, each bank holds 16K words.

Top module: `splitmem_top`

## Requirements
- R1: A read presented at address A makes `rdata` equal the word last written to A, one clock edge later; back-to-back reads give one result per cycle.
- R2: During a request, `bank_act` is 2'b01 when address bit 0 is 0 and 2'b10 when it is 1; at most one bit of `bank_act` is ever set.
- R3: In a cycle with neither `rd_en` nor `wr_en` asserted, `bank_act` is 2'b00.
- R4: Addresses 2k and 2k+1 use the same row index k in different banks and hold independent words.
- R5: The output multiplexer follows the bank-select bit registered at the request, so alternating odd and even reads return the correct word on every cycle.
- R6: After any number of idle cycles, `rdata` keeps the value of the last request.
- R7: A cycle with `wr_en` asserted returns on `rdata` the word stored before that write, whether or not `rd_en` is also set; a later read returns the new word.
- R8: A write changes only the bank picked by address bit 0; the word at the neighbouring address in the other bank is unchanged.
- R9: While `rst_n` is low, `rdata` is zero; with no request, `bank_act` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the read path |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| addr | input | ADDR_W | Word address; bit 0 chooses the bank |
| wdata | input | DATA_W | Word to store |
| rdata | output | DATA_W | Read word, one cycle after the request |
| bank_act | output | 2 | Per-bank enable for the current cycle |

## Verification
The hardest case to set up is the one where the registered select and the live address bit disagree. This happens when a read of one bank is followed at once by a request to the other bank, or by an idle cycle. The stimulus alternates odd and even addresses back to back across the whole space, then spaces reads apart with idle gaps. A mux that uses the live address bit, or that drops the registered bit during idle cycles, then returns the wrong word. Combined read-write cycles land beside words of the other bank that are already known. This exposes both stale-versus-new read ordering and writes that reach the wrong bank.

// File: rtl/splitmem_pkg.sv
package splitmem_pkg;
  localparam int NUM_BANKS = 2;

  function automatic logic bank_of(input logic [31:0] a);
    return a[0];
  endfunction

  function automatic logic [31:0] row_of(input logic [31:0] a);
    return a >> 1;
  endfunction
endpackage

// File: rtl/splitmem_decode.sv
module splitmem_decode
  import splitmem_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int ROW_W = ADDR_W - 1
) (
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_en,
  output logic [NUM_BANKS-1:0] bank_we,
  output logic [ROW_W-1:0]     row,
  output logic                 sel_bit,
  output logic                 req
);
  logic [31:0] addr_ext;

  always_comb begin
    addr_ext = 32'(addr);
    req      = rd_en | wr_en;
    sel_bit  = bank_of(addr_ext);
    row      = ROW_W'(row_of(addr_ext));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_dec
    assign bank_en[b] = req & (sel_bit == 1'(b));
    assign bank_we[b] = wr_en & (sel_bit == 1'(b));
  end
endmodule

// File: rtl/splitmem_bank.sv
module splitmem_bank #(
  parameter int ROW_W  = 9,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[row] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= mem[row];
  end
endmodule

// File: rtl/splitmem_rdmux.sv
module splitmem_rdmux
  import splitmem_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              capture,
  input  logic                              sel_in,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_q,
  output logic                              sel_q,
  output logic [DATA_W-1:0]                 rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)       sel_q <= 1'b0;
    else if (capture) sel_q <= sel_in;
  end

  assign rdata = bank_q[sel_q];
endmodule

// File: rtl/splitmem_top.sv
module splitmem_top
  import splitmem_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        bank_act
);
  localparam int ROW_W = ADDR_W - 1;

  logic [NUM_BANKS-1:0]             bank_en;
  logic [NUM_BANKS-1:0]             bank_we;
  logic [ROW_W-1:0]                 row;
  logic                             sel_bit;
  logic                             req;
  logic                             sel_q;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q;

  splitmem_decode #(.ADDR_W(ADDR_W)) u_dec (
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .bank_en(bank_en), .bank_we(bank_we), .row(row),
    .sel_bit(sel_bit), .req(req)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    splitmem_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .en(bank_en[b]), .we(bank_we[b]),
      .row(row), .wdata(wdata), .q(bank_q[b])
    );
  end

  splitmem_rdmux #(.DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .capture(req), .sel_in(sel_bit),
    .bank_q(bank_q), .sel_q(sel_q), .rdata(rdata)
  );

  assign bank_act = bank_en;
endmodule

// File: rtl/splitmem_chk.sv
module splitmem_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        bank_act,
  input logic [1:0]        bank_we,
  input logic              sel_q
);
  a_r2_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_act));

  a_r2_right_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> bank_act[addr[0]] && $countones(bank_act) == 1);

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |-> bank_act == 2'b00);

  a_r5_sel_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |=> sel_q == $past(addr[0]));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |=> $stable(rdata) && $stable(sel_q));

  a_r8_write_one: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> bank_we == bank_act);
endmodule

bind splitmem_top splitmem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .rdata(rdata), .bank_act(bank_act), .bank_we(bank_we), .sel_q(sel_q)
);

// File: tb/splitmem_top_test.sv
`timescale 1ns/1ps
module splitmem_top_test;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [1:0]    bank_act;

  int tests = 0;
  int fails = 0;

  logic [DW-1:0] model [N];
  bit            known [N];
  bit            pend_v = 1'b0;
  logic [DW-1:0] pend_x = '0;
  string         pend_tag = "";

  always #4 clk = ~clk;

  splitmem_top #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .bank_act(bank_act)
  );

  function automatic logic [DW-1:0] pat(input int a, input int seed);
    return (32'(a) * 32'h9E37_79B1) ^ (32'(seed) << 20) ^ 32'h00C3_A500;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: check the previous result, drive this request, check enables.
  task automatic step(input bit rd, input bit wr, input int a,
                      input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    if (pend_v) chk(rdata == pend_x, pend_tag, rdata, pend_x);
    rd_en = rd; wr_en = wr; addr = AW'(a); wdata = d;
    #1;
    if (rd || wr) begin
      chk(bank_act == ((a % 2) ? 2'b10 : 2'b01), "R2 bank enable",
          32'(bank_act), ((a % 2) ? 32'd2 : 32'd1));
      pend_v   = known[a];
      pend_x   = model[a];
      pend_tag = tag;
      if (wr) begin model[a] = d; known[a] = 1'b1; end
    end else begin
      chk(bank_act == 2'b00, "R3 idle enables", 32'(bank_act), 32'd0);
      pend_tag = "R6 hold across idle";
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) known[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(rdata == '0, "R9 reset rdata", rdata, '0);
    chk(bank_act == 2'b00, "R9 reset enables", 32'(bank_act), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // Fill every word (R4 independent neighbours)
    for (int a = 0; a < N; a++) step(1'b0, 1'b1, a, pat(a, 1), "R7 write old");
    // Back-to-back ascending reads, alternating banks (R1, R4, R5)
    for (int a = 0; a < N; a++) step(1'b1, 1'b0, a, '0, "R1 R4 R5 read");
    // Descending reads separated by idle gaps (R6)
    for (int a = N - 1; a >= 0; a -= 3) begin
      step(1'b1, 1'b0, a, '0, "R5 read after gap");
      step(1'b0, 1'b0, 0, '0, "");
      step(1'b0, 1'b0, 0, '0, "");
    end
    // Read-during-write returns old word (R7); neighbour untouched (R8)
    for (int a = 0; a < N; a += 5) begin
      step(1'b1, 1'b1, a, pat(a, 2), "R7 read during write");
      step(1'b1, 1'b0, a ^ 1, '0, "R8 neighbour intact");
      step(1'b1, 1'b0, a, '0, "R7 new word visible");
    end
    step(1'b0, 1'b0, 0, '0, "");
    @(negedge clk);
    if (pend_v) chk(rdata == pend_x, pend_tag, rdata, pend_x);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule